// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block sits inside a memory-mapped slave and works out where every beat of a burst lands. The slave's address-channel logic presents the start address, length field, size field and burst-type field of a newly accepted burst together with a one-cycle load strobe. From the next cycle the block drives the first beat's address, a beat index and a last-beat flag. Each time the slave completes a data handshake it pulses the advance strobe, and the block moves on to the following beat.

Three burst kinds are stepped. A fixed burst repeats the start address. An incrementing burst moves up by the beat size from the aligned start. A wrapping burst folds back to the lower edge of its window. Descriptors that are not allowed are flagged and stepped as incrementing bursts, so the slave always receives a well-defined sequence.

The controller has two states. IDLE has no burst in progress. RUN walks a burst. There are four transitions. IDLE goes to RUN on a load (`go`). RUN goes to RUN on a new load (`restart`) or on an advance that is not on the last beat (`step`). RUN goes to IDLE on an advance on the last beat (`retire`).

Top module: `burst_addr_gen`

## Requirements
- R1: During and after reset, before any load, busy_o, last_o and illegal_o are 0, and addr_o and beat_o are 0.
- R2: One cycle after load_i is high, busy_o is 1, addr_o equals the start address as given (even if unaligned) and beat_o is 0. A load takes precedence over advance_i and restarts a burst that is still in progress.
- R3: While busy_o is 1 and load_i is 0, each cycle with advance_i high moves beat_o up by one and updates addr_o on the next cycle. Without advance_i, addr_o and beat_o hold.
- R4: Burst type 2'b00 (fixed) keeps addr_o at the start address for every beat.
- R5: Burst type 2'b01 (incrementing) gives beat k (k from 0) the address floor(start / B) * B + k * B for k >= 1, where B = 2^size_i bytes.
- R6: Burst type 2'b10 (wrapping) uses the same step as R5. When the stepped address equals L + B*(len_i+1), with L the start address rounded down to a multiple of B*(len_i+1), the next address is L instead.
- R7: last_o is 1 exactly when busy_o is 1 and beat_o equals the loaded len_i. The burst has len_i+1 beats.
- R8: An advance on the last beat drops busy_o and last_o in the next cycle, and addr_o and beat_o keep their values. While idle, advance_i has no effect on any output.
- R9: illegal_o is set by a load whose type is 2'b11, or whose type is 2'b10 with len_i other than 1, 3, 7 or 15 or with a start address that is not a multiple of B. Such a burst is stepped as incrementing. illegal_o holds until the next load.
- R10: Address arithmetic is modulo 2^ADDR_W, so an incrementing burst near the top of the space continues from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture a new burst descriptor |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| len_i | input | 8 | Beats minus one |
| size_i | input | 3 | log2 of bytes per beat |
| burst_i | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| advance_i | input | 1 | Current beat has completed its handshake |
| busy_o | output | 1 | A burst is being walked |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | 8 | Index of the current beat from 0 |
| last_o | output | 1 | Current beat is the final one |
| illegal_o | output | 1 | Last loaded descriptor was not allowed |

## Verification
The bench's reference model follows the stated formulas with integer division and is compared with every output on every cycle. An unaligned incrementing start separates the aligned-step rule from a naive add of the beat size. Wrapping bursts that start mid-window, across sizes and lengths, check that the fold happens at the right upper edge and lands on the lower one. Fixed bursts, gapped advances, restarts in mid-burst, advances while idle, reserved and malformed wrapping descriptors, and a burst that runs past the top of the address space each isolate one of the hold, priority, fallback and modulo rules.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;
endpackage

// File: rtl/bag_decode.sv
// Classifies a descriptor at load time and precomputes the wrap window.
module bag_decode
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [1:0]        burst_i,
    output burst_e            mode_o,
    output logic              bad_o,
    output logic [ADDR_W-1:0] low_o,
    output logic [ADDR_W-1:0] high_o
);
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] span;
    logic              len_ok;
    logic              aligned;

    always_comb begin
        stride  = ADDR_W'(1) << size_i;
        span    = ADDR_W'({1'b0, len_i} + (LEN_W+1)'(1)) << size_i;
        len_ok  = (len_i == LEN_W'(1)) || (len_i == LEN_W'(3)) ||
                  (len_i == LEN_W'(7)) || (len_i == LEN_W'(15));
        aligned = ((start_i & (stride - ADDR_W'(1))) == '0);
        bad_o   = (burst_i == 2'b11) ||
                  ((burst_i == 2'b10) && !(len_ok && aligned));
        mode_o  = bad_o ? BT_INCR : burst_e'(burst_i);
        low_o   = start_i & ~(span - ADDR_W'(1));
        high_o  = low_o + span;
    end
endmodule

// File: rtl/bag_step.sv
// Next-beat address from the current one.
module bag_step
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [SIZE_W-1:0] size_i,
    input  burst_e            mode_i,
    input  logic [ADDR_W-1:0] low_i,
    input  logic [ADDR_W-1:0] high_i,
    output logic [ADDR_W-1:0] next_o
);
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] bumped;

    always_comb begin
        stride = ADDR_W'(1) << size_i;
        bumped = (cur_i & ~(stride - ADDR_W'(1))) + stride;
        unique case (mode_i)
            BT_FIXED: next_o = cur_i;
            BT_WRAP:  next_o = (bumped == high_i) ? low_i : bumped;
            default:  next_o = bumped;
        endcase
    end
endmodule

// File: rtl/bag_beat_ctr.sv
// Beat index with the loaded length as limit.
module bag_beat_ctr #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] beat_o,
    output logic             at_end_o
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
            lim_q <= len_i;
        end else if (step_i) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign beat_o   = cnt_q;
    assign at_end_o = (cnt_q == lim_q);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [7:0]        len_i,
    input  logic [2:0]        size_i,
    input  logic [1:0]        burst_i,
    input  logic              advance_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        beat_o,
    output logic              last_o,
    output logic              illegal_o
);
    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;

    state_e            state_q, state_d;
    burst_e            dec_mode, mode_q;
    logic              dec_bad, bad_q;
    logic [ADDR_W-1:0] dec_low, dec_high, low_q, high_q;
    logic [ADDR_W-1:0] addr_q, addr_next;
    logic [SIZE_W-1:0] size_q;
    logic [LEN_W-1:0]  beat;
    logic              at_end;
    logic              stepping;

    bag_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_dec (
        .start_i(start_addr_i), .len_i(len_i), .size_i(size_i), .burst_i(burst_i),
        .mode_o(dec_mode), .bad_o(dec_bad), .low_o(dec_low), .high_o(dec_high)
    );

    bag_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
        .cur_i(addr_q), .size_i(size_q), .mode_i(mode_q),
        .low_i(low_q), .high_i(high_q), .next_o(addr_next)
    );

    assign stepping = (state_q == ST_RUN) && advance_i && !load_i && !at_end;

    bag_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear_i(load_i), .step_i(stepping),
        .len_i(len_i), .beat_o(beat), .at_end_o(at_end)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: go, restart, step, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_RUN;
            ST_RUN:  if (!load_i && advance_i && at_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Burst context and current address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
            mode_q <= BT_FIXED;
            low_q  <= '0;
            high_q <= '0;
            bad_q  <= 1'b0;
        end else if (load_i) begin
            addr_q <= start_addr_i;
            size_q <= size_i;
            mode_q <= dec_mode;
            low_q  <= dec_low;
            high_q <= dec_high;
            bad_q  <= dec_bad;
        end else if (stepping) begin
            addr_q <= addr_next;
        end
    end

    // Outputs
    always_comb begin
        busy_o    = (state_q == ST_RUN);
        last_o    = (state_q == ST_RUN) && at_end;
        addr_o    = addr_q;
        beat_o    = beat;
        illegal_o = bad_q;
    end
endmodule

// File: rtl/bag_checks.sv
module bag_checks
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              advance_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              busy_o,
    input logic              last_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [7:0]        beat_o,
    input burst_e            mode
);
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o && (addr_o == $past(start_addr_i)) && (beat_o == 8'd0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !load_i && !advance_i |=> $stable(addr_o) && $stable(beat_o));

    p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && advance_i && !load_i && !last_o |=> beat_o == $past(beat_o) + 8'd1);

    p_fixed_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && advance_i && !load_i && (mode == BT_FIXED) |=> $stable(addr_o));

    p_last_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> busy_o);

    p_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && last_o && advance_i && !load_i |=> !busy_o && $stable(addr_o) && $stable(beat_o));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !load_i |=> !busy_o && $stable(addr_o) && $stable(beat_o));
endmodule

bind burst_addr_gen bag_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
    .start_addr_i(start_addr_i), .busy_o(busy_o), .last_o(last_o),
    .addr_o(addr_o), .beat_o(beat_o), .mode(mode_q)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [7:0]  len_i = '0;
    logic [2:0]  size_i = '0;
    logic [1:0]  burst_i = '0;
    logic        advance_i = 1'b0;
    logic        busy_o, last_o, illegal_o;
    logic [31:0] addr_o;
    logic [7:0]  beat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
        .len_i(len_i), .size_i(size_i), .burst_i(burst_i), .advance_i(advance_i),
        .busy_o(busy_o), .addr_o(addr_o), .beat_o(beat_o), .last_o(last_o),
        .illegal_o(illegal_o)
    );

    // Reference model state
    bit          m_busy = 0;
    bit          m_bad = 0;
    bit [31:0]   m_addr = 0, m_start = 0;
    int          m_beat = 0, m_len = 0, m_size = 0, m_mode = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] model_next();
        bit [31:0] nb, tot, low, n;
        nb = 32'd1 << m_size;
        n  = (m_addr / nb) * nb + nb;
        if (m_mode == 0) return m_addr;
        if (m_mode == 2) begin
            tot = nb * (m_len + 1);
            low = (m_start / tot) * tot;
            if (n == low + tot) return low;
        end
        return n;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_bad = 0; m_addr = 0; m_beat = 0; m_len = 0;
            m_size = 0; m_mode = 0; m_start = 0;
        end else if (load_i) begin
            bit [31:0] nb;
            nb = 32'd1 << size_i;
            m_busy = 1; m_addr = start_addr_i; m_start = start_addr_i;
            m_beat = 0; m_len = len_i; m_size = size_i;
            m_bad = (burst_i == 3) ||
                    (burst_i == 2 && (!(len_i == 1 || len_i == 3 || len_i == 7 || len_i == 15)
                                      || (start_addr_i % nb) != 0));
            m_mode = m_bad ? 1 : int'(burst_i);
        end else if (m_busy && advance_i) begin
            if (m_beat == m_len) m_busy = 0;
            else begin
                m_addr = model_next();
                m_beat++;
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            string atag;
            atag = m_bad ? "R9 addr" : (m_mode == 0) ? "R4 addr" : (m_mode == 2) ? "R6 addr" : "R5 addr";
            check(atag, addr_o, m_addr);
            check("R3 beat", beat_o, m_beat);
            check("R8 busy", busy_o, m_busy);
            check("R7 last", last_o, (m_busy && m_beat == m_len));
            check("R9 illegal", illegal_o, m_bad);
        end
    end

    // Load at a negedge, returns at the next negedge with load still high
    task automatic do_load(input bit [31:0] a, input int len, input int sz, input int bt, input bit adv);
        @(negedge clk);
        load_i = 1; start_addr_i = a; len_i = 8'(len); size_i = 3'(sz);
        burst_i = 2'(bt); advance_i = adv;
        @(negedge clk);
        check("R2 start", addr_o, a);
        check("R2 busy", busy_o, 1);
        load_i = 0; advance_i = 0;
    endtask

    task automatic run_burst(input bit [31:0] a, input int len, input int sz, input int bt, input bit gap);
        int n, k;
        do_load(a, len, sz, bt, 0);
        n = 0; k = 0;
        while (n <= len) begin
            advance_i = !(gap && (k % 3 == 1));
            if (advance_i) n++;
            k++;
            @(negedge clk);
        end
        advance_i = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", busy_o, 0);
        check("R1 addr", addr_o, 0);
        check("R1 beat", beat_o, 0);
        check("R1 last", last_o, 0);
        check("R1 illegal", illegal_o, 0);
        rst_n = 1;
        cmp_en = 1;
        @(negedge clk);

        // R5: unaligned incrementing start
        do_load(32'h1002, 3, 2, 1, 0);
        advance_i = 1; @(negedge clk);
        check("R5 aligned step", addr_o, 32'h1004);
        @(negedge clk);
        check("R5 third beat", addr_o, 32'h1008);
        advance_i = 0; @(negedge clk);
        check("R3 hold", addr_o, 32'h1008);
        advance_i = 1; repeat (2) @(negedge clk);
        advance_i = 0; @(negedge clk);
        check("R8 retired", busy_o, 0);

        // R6: wrap mid-window
        do_load(32'h38, 3, 2, 2, 0);
        advance_i = 1; repeat (2) @(negedge clk);
        check("R6 fold to low", addr_o, 32'h30);
        check("R7 not last yet", last_o, 0);
        @(negedge clk);
        check("R7 last beat", last_o, 1);
        @(negedge clk); advance_i = 0; @(negedge clk);

        run_burst(32'h77, 4, 0, 0, 1);        // R4 fixed with gaps
        run_burst(32'h1048, 15, 3, 2, 1);     // R6 long wrap
        run_burst(32'h205, 1, 0, 2, 0);       // R6 byte wrap of two
        run_burst(32'h40, 7, 4, 2, 0);        // R6 wide beats
        run_burst(32'h3, 20, 1, 1, 1);        // R5 unaligned halfwords
        run_burst(32'h100, 5, 2, 3, 0);       // R9 reserved type
        run_burst(32'h100, 2, 2, 2, 0);       // R9 wrap length three
        run_burst(32'h102, 3, 2, 2, 0);       // R9 unaligned wrap
        check("R9 flag held", illegal_o, 1);

        // R10: top of the address space
        do_load(32'hFFFF_FFF8, 3, 2, 1, 0);
        advance_i = 1; repeat (2) @(negedge clk);
        check("R10 rollover", addr_o, 32'h0);
        advance_i = 0;

        // R2: restart mid-burst, load beats a simultaneous advance
        do_load(32'h500, 7, 0, 1, 1);
        check("R2 restart beat", beat_o, 0);
        check("R9 cleared by load", illegal_o, 0);
        advance_i = 1; repeat (8) @(negedge clk);
        advance_i = 0; @(negedge clk);

        // R8: advance while idle changes nothing
        advance_i = 1; repeat (4) @(negedge clk);
        check("R8 idle addr", addr_o, 32'h507);
        check("R8 idle beat", beat_o, 7);
        check("R8 idle busy", busy_o, 0);
        advance_i = 0;

        run_burst(32'h0, 255, 7, 1, 0);       // R7 longest burst
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R3 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule